// File: doc/BRIEF.md
# Serial Register Controller with Header Line Steering

This block is a small register file that a host reaches through four general-purpose lines. One line clears the serial state, one is a strobe that marks bit times, one carries data from the host and one carries data back. The strobe never clocks any flop directly. The strobe, the host data and the clear line are synchronized into the system clock, and edges of the strobe are detected there. Each frame carries a direction bit, a register address and a data word, all sent most-significant bit first. On a read, the selected register is returned bit by bit during the data part of the frame.

The register contents steer every routed header line in one of three ways. A line can be driven from the host side onto the header, driven from the header onto the host side, or left undriven on both sides. Two further registers drive on-board LED outputs and enable lines for other devices on the board. Routed lines are modelled as separate input, output and output-enable vectors for each side, so the block needs no bidirectional port.

Top module: `sbc_ctrl`

## Requirements
- R1: A frame is exactly 25 rising strobe edges. The first bit is the direction (1 = read, 0 = write). The next 8 bits are the address and the last 16 bits are the data word, each field most-significant bit first. After the 25th rising edge the next rising edge begins a new frame.
- R2: Strobe and host data pass through two-flop synchronizers. The host data bit is taken at each rising strobe edge detected in the system clock domain.
- R3: A write changes a register only after the 25th rising edge of its frame has been taken. A frame cut short leaves every register unchanged.
- R4: In a read frame, the data output shows bit 15 of the selected register after the falling edge that follows the 9th rising edge. Each later falling edge moves to the next lower bit, so bit 0 is shown before the 25th rising edge. At all other times the data output is 0.
- R5: While the clear line is high, the frame position returns to the start and the data output goes to 0. Register contents are kept.
- R6: Writes to undefined addresses change nothing. Reads of undefined addresses return 0. The defined addresses are 0x00 and 0x01 (direction), 0x10 (LED) and 0x11 (enable).
- R7: Line j has a 2-bit direction code in the register at address j/8, in bits [2*(j%8)+1 : 2*(j%8)]. These bits read back as written. Unused bits read as 0.
- R8: Code 00 and code 11 leave the line undriven: both output enables are low and both outputs are 0.
- R9: Code 01 drives host-to-header. The header output enable is high and the header output follows the host input. The host side stays undriven, with its output at 0.
- R10: Code 10 drives header-to-host. The host output enable is high and the host output follows the header input. The header side stays undriven, with its output at 0.
- R11: The low 4 bits of register 0x10 drive the LED outputs, and the low 3 bits of register 0x11 drive the enable outputs. Higher bits of both registers are dropped on write and read back as 0.
- R12: After reset, every direction code is 00, the LED and enable outputs are 0, and the data output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Serial clear line from the host, active high |
| stb_i | input | 1 | Serial strobe from the host |
| din_i | input | 1 | Serial data from the host |
| dout_o | output | 1 | Serial data to the host |
| host_in | input | NL | Host-side line values |
| host_out | output | NL | Values driven onto host-side lines |
| host_oe | output | NL | Host-side output enables |
| hdr_in | input | NL | Header-side line values |
| hdr_out | output | NL | Values driven onto header lines |
| hdr_oe | output | NL | Header-side output enables |
| led_o | output | NLED | LED drive outputs |
| en_o | output | NEN | Enable lines for other board devices |

## Verification
The bench builds the block with 12 routed lines, 4 LEDs, 3 enables, an 8-bit address and a 16-bit data word. With 12 lines the direction codes fill one direction register and half of the next, so the bench sees a full register, a partly used register and its unused bits. Four rotated code patterns put every one of the four codes on every line. For each pattern the bench reads the registers back and drives two complementary input vectors, computing every expected output from the code it wrote. Short frames cut off by the clear line and frames stopped one bit before the end show that registers change only on a completed write.

// File: rtl/sbc_pkg.sv
`timescale 1ns/1ps
package sbc_pkg;
  typedef enum logic [1:0] {
    DIR_HIZ     = 2'b00,
    DIR_TO_HDR  = 2'b01,
    DIR_TO_HOST = 2'b10,
    DIR_RSVD    = 2'b11
  } dir_e;

  typedef enum logic [1:0] {PH_CMD, PH_ADDR, PH_DATA} phase_e;

  // strobe cycles per frame: direction bit, address, data
  function automatic int frame_len(input int aw, input int dw);
    return 1 + aw + dw;
  endfunction

  function automatic int dir_reg_of(input int line, input int dw);
    return line / (dw / 2);
  endfunction

  function automatic int dir_lsb_of(input int line, input int dw);
    return 2 * (line % (dw / 2));
  endfunction

  function automatic int dir_reg_count(input int nl, input int dw);
    return (2 * nl + dw - 1) / dw;
  endfunction
endpackage

// File: rtl/sbc_sync.sv
`timescale 1ns/1ps
module sbc_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/sbc_seq.sv
`timescale 1ns/1ps
module sbc_seq
  import sbc_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_s,
  input  logic          stb_s,
  input  logic          din_s,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          dout
);
  localparam int FL = frame_len(AW, DW);
  localparam int CW = $clog2(FL + 1);
  localparam logic [CW-1:0] LAST     = CW'(FL - 1);
  localparam logic [CW-1:0] ADDR_END = CW'(AW);

  logic          stb_d;
  logic [CW-1:0] cnt;
  logic          rw_q;
  logic [DW-2:0] sh;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] osh;
  logic          dout_q;
  phase_e        ph;

  // named internal events
  logic rise_w, fall_w, addr_done_w, last_w, rd_phase_w;

  always_comb begin
    if (cnt == '0)            ph = PH_CMD;
    else if (cnt <= ADDR_END) ph = PH_ADDR;
    else                      ph = PH_DATA;
  end

  assign rise_w      = stb_s & ~stb_d;
  assign fall_w      = ~stb_s & stb_d;
  assign addr_done_w = rise_w && (ph == PH_ADDR) && (cnt == ADDR_END);
  assign last_w      = rise_w && (cnt == LAST);
  assign rd_phase_w  = rw_q && (ph == PH_DATA);

  assign rd_addr = {sh[AW-2:0], din_s};
  assign wr_data = {sh[DW-2:0], din_s};
  assign wr_addr = addr_q;
  assign wr_en   = last_w && !rw_q && !clr_s;
  assign dout    = dout_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_d  <= 1'b0;
      cnt    <= '0;
      rw_q   <= 1'b0;
      sh     <= '0;
      addr_q <= '0;
      osh    <= '0;
      dout_q <= 1'b0;
    end else begin
      stb_d <= stb_s;
      if (clr_s) begin
        cnt    <= '0;
        rw_q   <= 1'b0;
        osh    <= '0;
        dout_q <= 1'b0;
      end else begin
        if (rise_w) begin
          if (ph == PH_CMD) rw_q <= din_s;
          else              sh   <= {sh[DW-3:0], din_s};
          cnt <= last_w ? '0 : cnt + 1'b1;
          if (addr_done_w) begin
            addr_q <= rd_addr;
            if (rw_q) osh <= rd_data;
          end
        end
        if (fall_w) begin
          if (rd_phase_w) begin
            dout_q <= osh[DW-1];
            osh    <= {osh[DW-2:0], 1'b0};
          end else begin
            dout_q <= 1'b0;
          end
        end
      end
    end
  end

  a_r1_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
  a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (last_w && !clr_s) |=> (cnt == '0));
  a_r2_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_w && ph != PH_CMD && !clr_s) |=> (sh[0] == $past(din_s)));
  a_r4_dout_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_w && !rd_phase_w) |=> !dout_q);
  a_r4_dout_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall_w && !clr_s) |=> $stable(dout_q));
  a_r5_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
    clr_s |=> (cnt == '0 && !dout_q));
endmodule

// File: rtl/sbc_regs.sv
`timescale 1ns/1ps
module sbc_regs
  import sbc_pkg::*;
#(
  parameter int NL       = 12,
  parameter int NLED     = 4,
  parameter int NEN      = 3,
  parameter int AW       = 8,
  parameter int DW       = 16,
  parameter int DIR_BASE = 'h00,
  parameter int LED_ADDR = 'h10,
  parameter int EN_ADDR  = 'h11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [AW-1:0]   rd_addr,
  output logic [DW-1:0]   rd_data,
  output logic [2*NL-1:0] dir_o,
  output logic [NLED-1:0] led_o,
  output logic [NEN-1:0]  en_o
);
  localparam int NDIR = dir_reg_count(NL, DW);

  logic [NLED-1:0] led_q;
  logic [NEN-1:0]  en_q;
  logic            wr_defined_w;

  for (genvar j = 0; j < NL; j++) begin : g_line
    localparam int RI  = dir_reg_of(j, DW);
    localparam int LSB = dir_lsb_of(j, DW);
    localparam logic [AW-1:0] RA = AW'(DIR_BASE + RI);
    logic [1:0] code_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       code_q <= DIR_HIZ;
      else if (wr_en && wr_addr == RA)  code_q <= wr_data[LSB +: 2];
    end
    assign dir_o[2*j +: 2] = code_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      led_q <= '0;
      en_q  <= '0;
    end else if (wr_en) begin
      if (wr_addr == AW'(LED_ADDR)) led_q <= wr_data[NLED-1:0];
      if (wr_addr == AW'(EN_ADDR))  en_q  <= wr_data[NEN-1:0];
    end
  end

  always_comb begin
    rd_data = '0;
    for (int j = 0; j < NL; j++) begin
      if (rd_addr == AW'(DIR_BASE + dir_reg_of(j, DW)))
        rd_data[dir_lsb_of(j, DW) +: 2] = dir_o[2*j +: 2];
    end
    if (rd_addr == AW'(LED_ADDR)) rd_data[NLED-1:0] = led_q;
    if (rd_addr == AW'(EN_ADDR))  rd_data[NEN-1:0]  = en_q;
  end

  assign wr_defined_w = ((int'(wr_addr) >= DIR_BASE) && (int'(wr_addr) < DIR_BASE + NDIR))
                        || (wr_addr == AW'(LED_ADDR)) || (wr_addr == AW'(EN_ADDR));

  assign led_o = led_q;
  assign en_o  = en_q;

  a_r3_change_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({dir_o, led_q, en_q}) |-> $past(wr_en));
  a_r6_undef_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_defined_w) |=> $stable({dir_o, led_q, en_q}));
  a_r11_led_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == AW'(LED_ADDR)) |=> (led_o == $past(wr_data[NLED-1:0])));
endmodule

// File: rtl/sbc_route.sv
`timescale 1ns/1ps
module sbc_route
  import sbc_pkg::*;
#(
  parameter int NL = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2*NL-1:0] dir_i,
  input  logic [NL-1:0]   host_in,
  input  logic [NL-1:0]   hdr_in,
  output logic [NL-1:0]   host_out,
  output logic [NL-1:0]   host_oe,
  output logic [NL-1:0]   hdr_out,
  output logic [NL-1:0]   hdr_oe
);
  for (genvar j = 0; j < NL; j++) begin : g_pin
    dir_e mode;
    assign mode = dir_e'(dir_i[2*j +: 2]);
    always_comb begin
      hdr_oe[j]   = 1'b0;
      hdr_out[j]  = 1'b0;
      host_oe[j]  = 1'b0;
      host_out[j] = 1'b0;
      case (mode)
        DIR_TO_HDR: begin
          hdr_oe[j]  = 1'b1;
          hdr_out[j] = host_in[j];
        end
        DIR_TO_HOST: begin
          host_oe[j]  = 1'b1;
          host_out[j] = hdr_in[j];
        end
        default: ;
      endcase
    end

    a_r8_one_driver: assert property (@(posedge clk) disable iff (!rst_n)
      !(hdr_oe[j] && host_oe[j]));
    a_r9_hdr_follows: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_oe[j] |-> (hdr_out[j] == host_in[j] && !host_out[j]));
    a_r10_host_follows: assert property (@(posedge clk) disable iff (!rst_n)
      host_oe[j] |-> (host_out[j] == hdr_in[j] && !hdr_out[j]));
  end
endmodule

// File: rtl/sbc_ctrl.sv
`timescale 1ns/1ps
module sbc_ctrl #(
  parameter int NL       = 12,
  parameter int NLED     = 4,
  parameter int NEN      = 3,
  parameter int AW       = 8,
  parameter int DW       = 16,
  parameter int DIR_BASE = 'h00,
  parameter int LED_ADDR = 'h10,
  parameter int EN_ADDR  = 'h11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic            stb_i,
  input  logic            din_i,
  output logic            dout_o,
  input  logic [NL-1:0]   host_in,
  output logic [NL-1:0]   host_out,
  output logic [NL-1:0]   host_oe,
  input  logic [NL-1:0]   hdr_in,
  output logic [NL-1:0]   hdr_out,
  output logic [NL-1:0]   hdr_oe,
  output logic [NLED-1:0] led_o,
  output logic [NEN-1:0]  en_o
);
  logic [2:0]      sync_w;
  logic            wr_en_w;
  logic [AW-1:0]   wr_addr_w, rd_addr_w;
  logic [DW-1:0]   wr_data_w, rd_data_w;
  logic [2*NL-1:0] dir_w;

  sbc_sync #(.W(3)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({clr_i, stb_i, din_i}),
    .q(sync_w)
  );

  sbc_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .clr_s(sync_w[2]), .stb_s(sync_w[1]), .din_s(sync_w[0]),
    .rd_data(rd_data_w), .rd_addr(rd_addr_w),
    .wr_en(wr_en_w), .wr_addr(wr_addr_w), .wr_data(wr_data_w),
    .dout(dout_o)
  );

  sbc_regs #(
    .NL(NL), .NLED(NLED), .NEN(NEN), .AW(AW), .DW(DW),
    .DIR_BASE(DIR_BASE), .LED_ADDR(LED_ADDR), .EN_ADDR(EN_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en_w), .wr_addr(wr_addr_w), .wr_data(wr_data_w),
    .rd_addr(rd_addr_w), .rd_data(rd_data_w),
    .dir_o(dir_w), .led_o(led_o), .en_o(en_o)
  );

  sbc_route #(.NL(NL)) u_route (
    .clk(clk), .rst_n(rst_n),
    .dir_i(dir_w), .host_in(host_in), .hdr_in(hdr_in),
    .host_out(host_out), .host_oe(host_oe),
    .hdr_out(hdr_out), .hdr_oe(hdr_oe)
  );
endmodule

// File: tb/sim_sbc_ctrl.sv
`timescale 1ns/1ps
module sim_sbc_ctrl;
  localparam int NL = 12, NLED = 4, NEN = 3, HALF = 6;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, clr = 1'b0, stb = 1'b0, din = 1'b0;
  logic dout;
  logic [NL-1:0] host_in = '0, hdr_in = '0;
  logic [NL-1:0] host_out, host_oe, hdr_out, hdr_oe;
  logic [NLED-1:0] led;
  logic [NEN-1:0] en;

  int checks = 0, errors = 0;

  sbc_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .stb_i(stb), .din_i(din),
    .dout_o(dout), .host_in(host_in), .host_out(host_out), .host_oe(host_oe),
    .hdr_in(hdr_in), .hdr_out(hdr_out), .hdr_oe(hdr_oe), .led_o(led), .en_o(en)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input bit b, output bit seen);
    @(negedge clk); din = b;
    repeat (HALF) @(negedge clk);
    seen = dout;
    stb = 1'b1;
    repeat (HALF) @(negedge clk);
    stb = 1'b0;
  endtask

  task automatic send_range(input bit [24:0] f, input int from, input int upto,
                            output bit [15:0] q);
    bit s;
    q = '0;
    for (int i = from; i <= upto; i++) begin
      send_bit(f[24-i], s);
      if (i >= 9) q[24-i] = s;
    end
    repeat (HALF) @(negedge clk);
  endtask

  task automatic wr(input bit [7:0] a, input bit [15:0] d);
    bit [15:0] q;
    send_range({1'b0, a, d}, 0, 24, q);
  endtask

  task automatic rd(input bit [7:0] a, output bit [15:0] q);
    send_range({1'b1, a, 16'h0}, 0, 24, q);
  endtask

  function automatic bit [1:0] pat_code(input int p, input int j);
    return 2'((j + p) % 4);
  endfunction

  function automatic bit [15:0] pat_word(input int p, input int r);
    bit [15:0] w = '0;
    for (int j = 0; j < NL; j++)
      if (j / 8 == r) w[2*(j%8) +: 2] = pat_code(p, j);
    return w;
  endfunction

  task automatic check_lines(input int p);
    bit [1:0] c;
    bit eho, ehd, vho, vhd;
    for (int j = 0; j < NL; j++) begin
      c = pat_code(p, j);
      ehd = (c == 2'b01);
      eho = (c == 2'b10);
      vhd = ehd ? host_in[j] : 1'b0;
      vho = eho ? hdr_in[j] : 1'b0;
      if (c == 2'b01)
        chk(hdr_oe[j] == 1 && hdr_out[j] == vhd && host_oe[j] == 0 && host_out[j] == 0,
            "R9 host-to-header", {hdr_oe[j], hdr_out[j], host_oe[j], host_out[j]}, {ehd, vhd, 2'b00});
      else if (c == 2'b10)
        chk(host_oe[j] == 1 && host_out[j] == vho && hdr_oe[j] == 0 && hdr_out[j] == 0,
            "R10 header-to-host", {hdr_oe[j], hdr_out[j], host_oe[j], host_out[j]}, {2'b00, eho, vho});
      else
        chk({hdr_oe[j], hdr_out[j], host_oe[j], host_out[j]} == 4'b0,
            "R8 undriven", {hdr_oe[j], hdr_out[j], host_oe[j], host_out[j]}, 0);
    end
  endtask

  initial begin
    #(150000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit [15:0] q;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12 reset state
    chk(hdr_oe == 0 && host_oe == 0 && led == 0 && en == 0 && dout == 0,
        "R12 reset outputs", {hdr_oe, host_oe, led, en, dout}, 0);
    rd(8'h00, q); chk(q == 16'h0, "R12 dir0 reset", q, 0);
    rd(8'h01, q); chk(q == 16'h0, "R12 dir1 reset", q, 0);

    // R1 R2 R11: MSb-first write seen at the LED pins
    wr(8'h10, 16'h0005);
    chk(led == 4'h5, "R1 led msb-first", led, 5);
    rd(8'h10, q); chk(q == 16'h0005, "R4 led readback", q, 5);
    wr(8'h10, 16'hFFFF);
    chk(led == 4'hF, "R11 led width", led, 4'hF);
    rd(8'h10, q); chk(q == 16'h000F, "R11 led high bits dropped", q, 16'h000F);
    wr(8'h11, 16'hFFFA);
    chk(en == 3'b010, "R11 enable pins", en, 3'b010);
    rd(8'h11, q); chk(q == 16'h0002, "R11 enable readback", q, 2);

    // R3 commit only after last bit
    send_range({1'b0, 8'h10, 16'h0009}, 0, 23, q);
    chk(led == 4'hF, "R3 no commit before last bit", led, 4'hF);
    send_range({1'b0, 8'h10, 16'h0009}, 24, 24, q);
    chk(led == 4'h9, "R3 commit after last bit", led, 9);

    // R5 clear aborts a partial write
    send_range({1'b0, 8'h10, 16'h0006}, 0, 11, q);
    clr = 1'b1; repeat (HALF) @(negedge clk);
    chk(dout == 0, "R5 dout cleared", dout, 0);
    clr = 1'b0; repeat (HALF) @(negedge clk);
    chk(led == 4'h9, "R5 led kept after clear", led, 9);
    rd(8'h10, q); chk(q == 16'h0009, "R5 fresh frame after clear", q, 9);
    // R5 clear aborts a partial read, then a full read works
    send_range({1'b1, 8'h11, 16'h0}, 0, 14, q);
    clr = 1'b1; repeat (HALF) @(negedge clk);
    chk(dout == 0, "R5 dout cleared mid-read", dout, 0);
    clr = 1'b0; repeat (HALF) @(negedge clk);
    rd(8'h11, q); chk(q == 16'h0002, "R5 read after aborted read", q, 2);

    // R6 undefined addresses
    wr(8'h22, 16'hFFFF);
    wr(8'h02, 16'hFFFF);
    chk(led == 4'h9 && en == 3'b010 && hdr_oe == 0 && host_oe == 0,
        "R6 undefined write ignored", {led, en}, {4'h9, 3'b010});
    rd(8'h22, q); chk(q == 16'h0, "R6 undefined read 0x22", q, 0);
    rd(8'h02, q); chk(q == 16'h0, "R6 undefined read 0x02", q, 0);
    rd(8'h00, q); chk(q == 16'h0, "R6 dir0 untouched", q, 0);

    // R4 back-to-back frames without clear, dout quiet on write frame
    wr(8'h00, 16'hA5C3);
    chk(dout == 0, "R4 dout zero after write frame", dout, 0);

    // R7..R10 sweep: every code on every line
    for (int p = 0; p < 4; p++) begin
      wr(8'h00, pat_word(p, 0));
      wr(8'h01, pat_word(p, 1) | 16'hFF00);
      rd(8'h00, q); chk(q == pat_word(p, 0), "R7 dir0 readback", q, pat_word(p, 0));
      rd(8'h01, q); chk(q == pat_word(p, 1), "R7 dir1 readback", q, pat_word(p, 1));
      for (int v = 0; v < 2; v++) begin
        @(negedge clk);
        host_in = (v == 0) ? 12'hA5C : 12'h5A3;
        hdr_in  = (v == 0) ? 12'h3C6 : 12'hC39;
        repeat (2) @(negedge clk);
        check_lines(p);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule